// File: doc/BRIEF.md
# Microcode Patch Match Redirect Unit

This unit sits beside a microcode sequencer and lets a small patch store override chosen entries of the read-only microcode. Eight match registers each hold a ROM triad address. Every cycle the sequencer offers its next ROM triad address. The unit compares that address against every enabled match register in parallel. On a hit it reports which entry matched. It then takes the sequencer over, starting at the patch RAM triad with the same index as the matching register.

While it is in charge, the unit reads one patch triad at a time from an external synchronous patch RAM. It only looks at the 32-bit sequence-control word of each triad. That word either passes control to the following triad or ends the patch and returns control to the ROM flow. If a patch runs off the end of the patch RAM without ending, an overflow error is flagged and control goes back to ROM anyway. Match registers are written through a simple indexed port, and only while the patch-load input is high.

Top module: `ucode_patch_redirect`

## Requirements
- R1: Synchronous reset sets all eight 32-bit match registers to 0xFFFFFFFF. Right after reset, no sequencer address produces a hit, and `busy`, `redir_q`, `pram_rd_en`, `rom_return` and `ovf_err` are all low.
- R2: A match register holding 0xFFFFFFFF never hits. Any other value hits when its bits [11:0] equal `seq_addr`; bits [31:12] take no part in the compare.
- R3: `redir_hit` and `redir_slot` respond combinationally to `seq_addr` in the same cycle. When several registers hit, `redir_slot` gives the lowest index.
- R4: `redir_q` and `redir_slot_q` repeat `redir_hit` and `redir_slot` one clock later.
- R5: A write through `mr_we` takes effect only while `load_en` is high. While `load_en` is high, no hit is reported.
- R6: With `seq_vld` low, no hit is reported.
- R7: A hit on register i issues a patch read of triad i in the next cycle. Each read is followed by one check cycle with `pram_rd_en` low. In that check cycle, bit 0 of `pram_seq` equal to 0 means "go to the next triad", and the read of triad +1 follows in the next cycle.
- R8: When bit 0 of `pram_seq` is 1 in a check cycle, the patch completes. In the next cycle `rom_return` pulses for one cycle and `busy` is low.
- R9: A "next" code read from triad 15 raises `ovf_err` for one cycle together with `rom_return`, and no further triad is read.
- R10: While `busy` is high, the sequencer address produces no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Patch-load mode: enables register writes and suppresses hits |
| mr_we | input | 1 | Match register write enable |
| mr_idx | input | 3 | Match register index to write |
| mr_wdata | input | 32 | Match register write value |
| seq_vld | input | 1 | Sequencer address valid |
| seq_addr | input | 12 | Next ROM triad address from the sequencer |
| redir_hit | output | 1 | Combinational hit |
| redir_slot | output | 3 | Combinational index of the winning match register |
| redir_q | output | 1 | Registered hit |
| redir_slot_q | output | 3 | Registered winning index |
| busy | output | 1 | Executing from patch RAM |
| pram_rd_en | output | 1 | Patch RAM read enable |
| pram_rd_addr | output | 4 | Patch RAM triad index to read |
| pram_seq | input | 32 | Sequence-control word, valid the cycle after a read |
| rom_return | output | 1 | One-cycle pulse when control returns to ROM |
| ovf_err | output | 1 | One-cycle pulse when a patch runs past the last triad |

## Verification
A corrupted match register or a wrong priority order shows up in the same cycle as a wrong `redir_hit` or `redir_slot` for one particular address. For that reason every one of the 4096 addresses is probed against two register images. A wrong triad pointer or sequencer state shows up one to two cycles later, as a wrong `pram_rd_addr`, a missing check cycle, or a `rom_return` or `ovf_err` on the wrong cycle. The bench follows each patch walk triad by triad and checks the exit pulse cycle-exactly.

// File: rtl/upr_pkg.sv
package upr_pkg;
  typedef enum logic [1:0] {
    ST_ROM = 2'd0,
    ST_RD  = 2'd1,
    ST_CHK = 2'd2
  } upr_state_e;

  localparam logic [31:0] MR_OFF = 32'hFFFF_FFFF;
endpackage

// File: rtl/upr_match_bank.sv
module upr_match_bank #(
  parameter int N_MATCH = 8,
  parameter int MATCH_W = 32,
  parameter int TADDR_W = 12,
  localparam int SLOT_W = $clog2(N_MATCH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [SLOT_W-1:0]  wr_idx,
  input  logic [MATCH_W-1:0] wr_data,
  input  logic [TADDR_W-1:0] probe,
  output logic               any_hit,
  output logic [SLOT_W-1:0]  win_slot
);
  logic [MATCH_W-1:0] mreg [N_MATCH];
  logic [N_MATCH-1:0] hit_vec;

  genvar gi;
  generate
    for (gi = 0; gi < N_MATCH; gi++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst)
          mreg[gi] <= '1;
        else if (wr_en && wr_idx == SLOT_W'(gi))
          mreg[gi] <= wr_data;
      end
      assign hit_vec[gi] = (mreg[gi] != {MATCH_W{1'b1}}) &&
                           (mreg[gi][TADDR_W-1:0] == probe);
    end
  endgenerate

  always_comb begin
    win_slot = '0;
    for (int k = N_MATCH - 1; k >= 0; k--)
      if (hit_vec[k]) win_slot = SLOT_W'(k);
  end

  assign any_hit = |hit_vec;
endmodule

// File: rtl/upr_triad_stepper.sv
module upr_triad_stepper
  import upr_pkg::*;
#(
  parameter int N_MATCH  = 8,
  parameter int N_TRIAD  = 16,
  parameter int SEQ_W    = 32,
  parameter int CMPL_BIT = 0,
  localparam int SLOT_W = $clog2(N_MATCH),
  localparam int TRI_W  = $clog2(N_TRIAD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SEQ_W-1:0]  seq_word,
  output logic              busy,
  output logic              redir_q,
  output logic [SLOT_W-1:0] redir_slot_q,
  output logic              rd_en,
  output logic [TRI_W-1:0]  rd_addr,
  output logic              rom_return,
  output logic              ovf_err
);
  localparam logic [TRI_W-1:0] LAST = TRI_W'(N_TRIAD - 1);

  upr_state_e        state;
  logic [TRI_W-1:0]  cur;
  logic              seq_done;
  logic [SEQ_W-1:0]  unused_seq;

  assign seq_done   = seq_word[CMPL_BIT];
  assign unused_seq = seq_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_ROM;
      cur          <= '0;
      redir_q      <= 1'b0;
      redir_slot_q <= '0;
      rom_return   <= 1'b0;
      ovf_err      <= 1'b0;
    end else begin
      redir_q      <= hit;
      redir_slot_q <= slot;
      rom_return   <= 1'b0;
      ovf_err      <= 1'b0;
      unique case (state)
        ST_ROM: if (hit) begin
          state <= ST_RD;
          cur   <= TRI_W'(slot);
        end
        ST_RD: state <= ST_CHK;
        ST_CHK: begin
          if (seq_done) begin
            state      <= ST_ROM;
            rom_return <= 1'b1;
          end else if (cur == LAST) begin
            state      <= ST_ROM;
            rom_return <= 1'b1;
            ovf_err    <= 1'b1;
          end else begin
            state <= ST_RD;
            cur   <= cur + 1'b1;
          end
        end
        default: state <= ST_ROM;
      endcase
    end
  end

  assign busy    = (state != ST_ROM);
  assign rd_en   = (state == ST_RD);
  assign rd_addr = cur;
endmodule

// File: rtl/ucode_patch_redirect.sv
module ucode_patch_redirect #(
  parameter int N_MATCH  = 8,
  parameter int MATCH_W  = 32,
  parameter int TADDR_W  = 12,
  parameter int N_TRIAD  = 16,
  parameter int SEQ_W    = 32,
  parameter int CMPL_BIT = 0,
  localparam int SLOT_W = $clog2(N_MATCH),
  localparam int TRI_W  = $clog2(N_TRIAD)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic               mr_we,
  input  logic [SLOT_W-1:0]  mr_idx,
  input  logic [MATCH_W-1:0] mr_wdata,
  input  logic               seq_vld,
  input  logic [TADDR_W-1:0] seq_addr,
  output logic               redir_hit,
  output logic [SLOT_W-1:0]  redir_slot,
  output logic               redir_q,
  output logic [SLOT_W-1:0]  redir_slot_q,
  output logic               busy,
  output logic               pram_rd_en,
  output logic [TRI_W-1:0]   pram_rd_addr,
  input  logic [SEQ_W-1:0]   pram_seq,
  output logic               rom_return,
  output logic               ovf_err
);
  logic raw_hit;

  upr_match_bank #(
    .N_MATCH (N_MATCH),
    .MATCH_W (MATCH_W),
    .TADDR_W (TADDR_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (load_en && mr_we),
    .wr_idx   (mr_idx),
    .wr_data  (mr_wdata),
    .probe    (seq_addr),
    .any_hit  (raw_hit),
    .win_slot (redir_slot)
  );

  assign redir_hit = raw_hit && seq_vld && !load_en && !busy;

  upr_triad_stepper #(
    .N_MATCH  (N_MATCH),
    .N_TRIAD  (N_TRIAD),
    .SEQ_W    (SEQ_W),
    .CMPL_BIT (CMPL_BIT)
  ) u_step (
    .clk          (clk),
    .rst          (rst),
    .hit          (redir_hit),
    .slot         (redir_slot),
    .seq_word     (pram_seq),
    .busy         (busy),
    .redir_q      (redir_q),
    .redir_slot_q (redir_slot_q),
    .rd_en        (pram_rd_en),
    .rd_addr      (pram_rd_addr),
    .rom_return   (rom_return),
    .ovf_err      (ovf_err)
  );
endmodule

// File: rtl/upr_checker.sv
module upr_checker #(
  parameter int SLOT_W = 3,
  parameter int TRI_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              load_en,
  input logic              seq_vld,
  input logic              redir_hit,
  input logic [SLOT_W-1:0] redir_slot,
  input logic              redir_q,
  input logic [SLOT_W-1:0] redir_slot_q,
  input logic              busy,
  input logic              pram_rd_en,
  input logic [TRI_W-1:0]  pram_rd_addr,
  input logic              rom_return,
  input logic              ovf_err
);
  localparam logic [TRI_W-1:0] LAST = '1;

  p_reg_redir_r4: assert property (@(posedge clk) disable iff (rst)
    redir_hit |=> redir_q && redir_slot_q == $past(redir_slot));

  p_first_read_r7: assert property (@(posedge clk) disable iff (rst)
    redir_q |-> pram_rd_en && pram_rd_addr == TRI_W'(redir_slot_q));

  p_read_then_check_r7: assert property (@(posedge clk) disable iff (rst)
    pram_rd_en |=> !pram_rd_en && busy);

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !redir_hit);

  p_return_idle_r8: assert property (@(posedge clk) disable iff (rst)
    rom_return |-> !busy && !pram_rd_en);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> rom_return && $past(pram_rd_addr) == LAST);

  p_load_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    load_en && seq_vld |=> !redir_q);
endmodule

bind ucode_patch_redirect upr_checker #(
  .SLOT_W (SLOT_W),
  .TRI_W  (TRI_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .load_en      (load_en),
  .seq_vld      (seq_vld),
  .redir_hit    (redir_hit),
  .redir_slot   (redir_slot),
  .redir_q      (redir_q),
  .redir_slot_q (redir_slot_q),
  .busy         (busy),
  .pram_rd_en   (pram_rd_en),
  .pram_rd_addr (pram_rd_addr),
  .rom_return   (rom_return),
  .ovf_err      (ovf_err)
);

// File: tb/test_ucode_patch_redirect.sv
`timescale 1ns/1ps
module test_ucode_patch_redirect;
  logic        clk = 1'b0;
  logic        rst;
  logic        load_en, mr_we, seq_vld;
  logic [2:0]  mr_idx;
  logic [31:0] mr_wdata;
  logic [11:0] seq_addr;
  logic        redir_hit, redir_q, busy, pram_rd_en, rom_return, ovf_err;
  logic [2:0]  redir_slot, redir_slot_q;
  logic [3:0]  pram_rd_addr;
  logic [31:0] pram_seq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] img [8];
  logic [31:0] tmem [16];

  always #10 clk = ~clk;

  ucode_patch_redirect i_ucode_patch_redirect (
    .clk(clk), .rst(rst), .load_en(load_en), .mr_we(mr_we), .mr_idx(mr_idx),
    .mr_wdata(mr_wdata), .seq_vld(seq_vld), .seq_addr(seq_addr),
    .redir_hit(redir_hit), .redir_slot(redir_slot), .redir_q(redir_q),
    .redir_slot_q(redir_slot_q), .busy(busy), .pram_rd_en(pram_rd_en),
    .pram_rd_addr(pram_rd_addr), .pram_seq(pram_seq),
    .rom_return(rom_return), .ovf_err(ovf_err)
  );

  always @(posedge clk) if (pram_rd_en) pram_seq <= tmem[pram_rd_addr];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void expect_hit(input logic [11:0] a, output bit found, output logic [2:0] s);
    found = 1'b0; s = '0;
    for (int j = 7; j >= 0; j--)
      if (img[j] != 32'hFFFF_FFFF && img[j][11:0] == a) begin found = 1'b1; s = 3'(j); end
  endfunction

  task automatic wr_mr(input int idx, input logic [31:0] d, input bit upd);
    @(negedge clk);
    mr_we = 1'b1; mr_idx = 3'(idx); mr_wdata = d;
    @(negedge clk);
    mr_we = 1'b0;
    if (upd) img[idx] = d;
  endtask

  task automatic sweep();
    bit f; logic [2:0] s;
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      seq_vld = 1'b1; seq_addr = 12'(a);
      expect_hit(12'(a), f, s);
      #1;
      check(redir_hit == f && (!f || redir_slot == s), "R2/R3 comb hit",
            {28'd0, redir_hit, redir_slot}, {28'd0, f, s});
      @(negedge clk);
      seq_vld = 1'b0;
      check(redir_q == f && (!f || redir_slot_q == s), "R4 registered hit",
            {28'd0, redir_q, redir_slot_q}, {28'd0, f, s});
      if (f) begin
        @(negedge clk);
        @(negedge clk);
      end
    end
  endtask

  task automatic run_patch(input int i, input int last_k);
    int j;
    @(negedge clk);
    seq_vld = 1'b1; seq_addr = img[i][11:0];
    #1;
    check(redir_hit && redir_slot == 3'(i), "R3 patch entry hit", {31'd0, redir_hit}, 32'd1);
    @(negedge clk);
    #1;
    check(redir_q && redir_slot_q == 3'(i), "R4 entry slot", {29'd0, redir_slot_q}, i);
    check(!redir_hit, "R10 no hit while busy", {31'd0, redir_hit}, 32'd0);
    seq_vld = 1'b0;
    j = i;
    forever begin
      check(pram_rd_en && pram_rd_addr == 4'(j), "R7 triad read",
            {27'd0, pram_rd_en, pram_rd_addr}, {27'd0, 1'b1, 4'(j)});
      @(negedge clk);
      check(!pram_rd_en && busy, "R7 check cycle", {30'd0, pram_rd_en, busy}, 32'd1);
      @(negedge clk);
      if (j == last_k) begin
        check(rom_return && !busy && !ovf_err, "R8 complete return",
              {29'd0, rom_return, busy, ovf_err}, 32'd4);
        break;
      end else if (j == 15) begin
        check(rom_return && ovf_err && !busy && !pram_rd_en, "R9 overflow",
              {29'd0, rom_return, busy, ovf_err}, 32'd5);
        break;
      end
      j++;
    end
    @(negedge clk);
    check(!rom_return && !ovf_err && !busy, "R8 single pulse",
          {29'd0, rom_return, ovf_err, busy}, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; load_en = 1'b0; mr_we = 1'b0; mr_idx = '0; mr_wdata = '0;
    seq_vld = 1'b0; seq_addr = '0;
    for (int k = 0; k < 16; k++) tmem[k] = 32'h1;
    for (int k = 0; k < 8; k++) img[k] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!busy && !redir_q && !pram_rd_en && !rom_return && !ovf_err, "R1 reset outputs",
          {27'd0, busy, redir_q, pram_rd_en, rom_return, ovf_err}, 32'd0);
    seq_vld = 1'b1; seq_addr = 12'hFFF;
    #1;
    check(!redir_hit, "R1 no hit on FFF after reset", {31'd0, redir_hit}, 32'd0);
    seq_addr = 12'h000;
    #1;
    check(!redir_hit, "R1 no hit on 000 after reset", {31'd0, redir_hit}, 32'd0);
    seq_vld = 1'b0;

    load_en = 1'b1;
    wr_mr(0, 32'hABC0_0123, 1'b1);
    wr_mr(1, 32'hFFFF_FFFF, 1'b1);
    wr_mr(2, 32'h0000_0FFF, 1'b1);
    wr_mr(3, 32'h1234_5123, 1'b1);
    wr_mr(4, 32'h0000_0400, 1'b1);
    wr_mr(5, 32'hFFFF_F7FF, 1'b1);
    wr_mr(6, 32'h7770_0400, 1'b1);
    wr_mr(7, 32'h0000_0000, 1'b1);
    @(negedge clk);
    seq_vld = 1'b1; seq_addr = 12'h123;
    #1;
    check(!redir_hit, "R5 hit suppressed during load", {31'd0, redir_hit}, 32'd0);
    @(negedge clk);
    check(!redir_q && !busy, "R5 no redirect during load", {30'd0, redir_q, busy}, 32'd0);
    seq_vld = 1'b0; load_en = 1'b0;

    wr_mr(1, 32'h0000_0222, 1'b0);
    @(negedge clk);
    seq_vld = 1'b1; seq_addr = 12'h222;
    #1;
    check(!redir_hit, "R5 write ignored without load", {31'd0, redir_hit}, 32'd0);
    seq_vld = 1'b0; seq_addr = 12'h123;
    #1;
    check(!redir_hit, "R6 no hit with valid low", {31'd0, redir_hit}, 32'd0);
    @(negedge clk);
    check(!redir_q, "R6 no registered hit with valid low", {31'd0, redir_q}, 32'd0);

    sweep();

    load_en = 1'b1;
    for (int k = 0; k < 8; k++) wr_mr(k, 32'h5A00_0000 | (32'h100 + 32'h11 * k), 1'b1);
    load_en = 1'b0;
    sweep();

    for (int i = 0; i < 8; i++) begin
      int kk;
      kk = i + ((i * 3) % 5);
      for (int k = 0; k < 16; k++) tmem[k] = (k == kk) ? 32'h0000_0001 : 32'hFFFF_FFFE;
      run_patch(i, kk);
    end
    for (int k = 0; k < 16; k++) tmem[k] = 32'hFFFF_FFFE;
    for (int i = 0; i < 8; i++) run_patch(i, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule